// File: doc/BRIEF.md
# Short Branch Target Unit

This unit resolves the two short PC-relative branch forms of a 16-bit instruction stream. Each cycle that `in_valid` is high it takes one instruction halfword, the address that halfword was fetched from and the current N, Z, C and V flags. One clock later it presents the decision: whether the instruction redirects the fetch, the next fetch address, and whether the halfword instead encodes an undefined instruction or a software interrupt.

The next fetch address is the branch destination when the branch is taken and the sequential address (instruction address plus 2) in every other case. The destination is formed from a base of the instruction address plus 4, to which the halfword-scaled, sign-extended offset field is added, with all arithmetic wrapping modulo 2^32. Pipeline flush and address range checks are handled elsewhere.

Top module: `sbt_branch_unit`

## Requirements
- R1: Every cycle with `in_valid` high yields exactly one cycle of `out_valid` high on the following clock edge; with `in_valid` low, `out_valid` is low one edge later.
- R2: A halfword with bits [15:12] = 1101 and bits [11:8] in 0000..1101 is a conditional branch; its destination is address + 4 + 2 * (bits [7:0] as a signed value), covering byte offsets -256 to +254.
- R3: A halfword with bits [15:11] = 11100 is an unconditional branch, always taken, with destination address + 4 + 2 * (bits [10:0] as a signed value), covering -2048 to +2046.
- R4: A conditional-form halfword with bits [11:8] = 1110 raises `undef`, is not taken, and gives target address + 2.
- R5: A conditional-form halfword with bits [11:8] = 1111 raises `swi`, is not taken, and gives target address + 2.
- R6: The condition field selects: 0 Z, 1 !Z, 2 C, 3 !C, 4 N, 5 !N, 6 V, 7 !V, 8 C&!Z, 9 !C|Z, 10 N==V, 11 N!=V, 12 !Z&(N==V), 13 Z|(N!=V); the branch is taken exactly when the selected term is 1.
- R7: A halfword of neither branch form, or a conditional branch whose condition fails, gives `br_taken` = 0, `undef` = 0, `swi` = 0 and target address + 2.
- R8: All address sums wrap modulo 2^32 with no error indication.
- R9: After reset, and until the first accepted input, `out_valid`, `br_taken`, `undef`, `swi` are 0 and `br_target` is 0.
- R10: At most one of `br_taken`, `undef`, `swi` is high in any cycle.
- R11: For an even instruction address the target is always even.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Halfword and address are valid this cycle |
| insn | input | 16 | Instruction halfword |
| pc | input | 32 | Address of the instruction halfword |
| flag_n | input | 1 | Negative flag |
| flag_z | input | 1 | Zero flag |
| flag_c | input | 1 | Carry flag |
| flag_v | input | 1 | Overflow flag |
| out_valid | output | 1 | Result registered from the previous cycle's input |
| br_taken | output | 1 | Fetch redirects to `br_target` |
| br_target | output | 32 | Next fetch address |
| undef | output | 1 | Halfword is the reserved undefined condition encoding |
| swi | output | 1 | Halfword is the software-interrupt condition encoding |

## Verification
Every result, the taken flag, the target, and both exception indications, is due exactly one rising edge after the cycle that presented the input, since a single register stage sits between the inputs and all outputs. The driver changes inputs on the falling edge and queues the expected result at that moment; the monitor inspects the outputs on the following falling edge, so each comparison lands half a period after the register updates. A valid output with nothing queued, or a queued item left after the stream drains, counts as a failure of the one-cycle timing rule.

// File: rtl/sbt_pkg.sv
package sbt_pkg;

    localparam int SBT_ADDR_W = 32;
    localparam int SBT_INSN_W = 16;

    typedef logic [SBT_ADDR_W-1:0] addr_t;

    typedef struct packed {
        logic  valid;
        logic  taken;
        logic  undef;
        logic  swi;
        addr_t target;
    } sbt_result_t;

    typedef enum logic [1:0] {
        KIND_NONE   = 2'd0,
        KIND_COND   = 2'd1,
        KIND_UNCOND = 2'd2
    } sbt_kind_e;

endpackage

// File: rtl/sbt_cond_eval.sv
module sbt_cond_eval (
    input  logic [3:0] cond,
    input  logic       flag_n,
    input  logic       flag_z,
    input  logic       flag_c,
    input  logic       flag_v,
    output logic       pass
);
    logic nv_eq;

    always_comb begin
        nv_eq = (flag_n == flag_v);
        unique case (cond)
            4'h0:    pass = flag_z;
            4'h1:    pass = !flag_z;
            4'h2:    pass = flag_c;
            4'h3:    pass = !flag_c;
            4'h4:    pass = flag_n;
            4'h5:    pass = !flag_n;
            4'h6:    pass = flag_v;
            4'h7:    pass = !flag_v;
            4'h8:    pass = flag_c && !flag_z;
            4'h9:    pass = !flag_c || flag_z;
            4'hA:    pass = nv_eq;
            4'hB:    pass = !nv_eq;
            4'hC:    pass = !flag_z && nv_eq;
            4'hD:    pass = flag_z || !nv_eq;
            default: pass = 1'b0;
        endcase
    end
endmodule

// File: rtl/sbt_decode.sv
module sbt_decode
    import sbt_pkg::*;
#(
    parameter int COND_OFF_W   = 8,
    parameter int UNCOND_OFF_W = 11
) (
    input  logic [SBT_INSN_W-1:0] insn,
    output sbt_kind_e             kind,
    output logic [3:0]            cond,
    output addr_t                 offset
);
    localparam int COND_PAD   = SBT_ADDR_W - COND_OFF_W - 1;
    localparam int UNCOND_PAD = SBT_ADDR_W - UNCOND_OFF_W - 1;

    addr_t cond_ofs;
    addr_t uncond_ofs;

    assign cond_ofs   = {{COND_PAD{insn[COND_OFF_W-1]}}, insn[COND_OFF_W-1:0], 1'b0};
    assign uncond_ofs = {{UNCOND_PAD{insn[UNCOND_OFF_W-1]}}, insn[UNCOND_OFF_W-1:0], 1'b0};
    assign cond       = insn[11:8];

    always_comb begin
        if (insn[15:12] == 4'b1101) begin
            kind   = KIND_COND;
            offset = cond_ofs;
        end else if (insn[15:11] == 5'b11100) begin
            kind   = KIND_UNCOND;
            offset = uncond_ofs;
        end else begin
            kind   = KIND_NONE;
            offset = '0;
        end
    end
endmodule

// File: rtl/sbt_target_add.sv
module sbt_target_add
    import sbt_pkg::*;
(
    input  addr_t pc,
    input  addr_t offset,
    output addr_t branch_dest,
    output addr_t seq_next
);
    localparam addr_t BASE_STEP = addr_t'(4);
    localparam addr_t SEQ_STEP  = addr_t'(2);

    addr_t base;

    assign base        = pc + BASE_STEP;
    assign branch_dest = base + offset;
    assign seq_next    = pc + SEQ_STEP;
endmodule

// File: rtl/sbt_branch_unit.sv
module sbt_branch_unit
    import sbt_pkg::*;
#(
    parameter int COND_OFF_W   = 8,
    parameter int UNCOND_OFF_W = 11
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_valid,
    input  logic [15:0] insn,
    input  logic [31:0] pc,
    input  logic        flag_n,
    input  logic        flag_z,
    input  logic        flag_c,
    input  logic        flag_v,
    output logic        out_valid,
    output logic        br_taken,
    output logic [31:0] br_target,
    output logic        undef,
    output logic        swi
);
    localparam logic [3:0] COND_UNDEF = 4'hE;
    localparam logic [3:0] COND_SWI   = 4'hF;

    sbt_kind_e   kind;
    logic [3:0]  cond;
    addr_t       offset;
    addr_t       branch_dest;
    addr_t       seq_next;
    logic        cond_pass;
    sbt_result_t res_d;
    sbt_result_t res_q;

    sbt_decode #(
        .COND_OFF_W   (COND_OFF_W),
        .UNCOND_OFF_W (UNCOND_OFF_W)
    ) u_decode (
        .insn   (insn),
        .kind   (kind),
        .cond   (cond),
        .offset (offset)
    );

    sbt_cond_eval u_cond (
        .cond   (cond),
        .flag_n (flag_n),
        .flag_z (flag_z),
        .flag_c (flag_c),
        .flag_v (flag_v),
        .pass   (cond_pass)
    );

    sbt_target_add u_add (
        .pc          (pc),
        .offset      (offset),
        .branch_dest (branch_dest),
        .seq_next    (seq_next)
    );

    always_comb begin
        res_d        = res_q;
        res_d.valid  = in_valid;
        if (in_valid) begin
            res_d.taken  = 1'b0;
            res_d.undef  = 1'b0;
            res_d.swi    = 1'b0;
            res_d.target = seq_next;
            unique case (kind)
                KIND_UNCOND: begin
                    res_d.taken  = 1'b1;
                    res_d.target = branch_dest;
                end
                KIND_COND: begin
                    if (cond == COND_UNDEF) begin
                        res_d.undef = 1'b1;
                    end else if (cond == COND_SWI) begin
                        res_d.swi = 1'b1;
                    end else if (cond_pass) begin
                        res_d.taken  = 1'b1;
                        res_d.target = branch_dest;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q <= '0;
        end else begin
            res_q <= res_d;
        end
    end

    assign out_valid = res_q.valid;
    assign br_taken  = res_q.taken;
    assign br_target = res_q.target;
    assign undef     = res_q.undef;
    assign swi       = res_q.swi;

    assert_valid_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    assert_idle_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    assert_uncond_taken_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && insn[15:11] == 5'b11100) |=> br_taken);

    assert_undef_no_branch_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && insn[15:12] == 4'b1101 && insn[11:8] == 4'hE)
        |=> (undef && !br_taken && br_target == $past(pc) + 32'd2));

    assert_swi_no_branch_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && insn[15:12] == 4'b1101 && insn[11:8] == 4'hF)
        |=> (swi && !br_taken && br_target == $past(pc) + 32'd2));

    assert_not_taken_seq_R7: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (br_taken || br_target == $past(pc) + 32'd2));

    assert_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({br_taken, undef, swi}));

    assert_even_target_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !pc[0]) |=> !br_target[0]);

endmodule

// File: tb/sbt_branch_unit_bench.sv
module sbt_branch_unit_bench;

    typedef struct packed {
        logic        taken;
        logic        undef;
        logic        swi;
        logic [31:0] target;
        logic [7:0]  req;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [15:0] insn = '0;
    logic [31:0] pc = '0;
    logic        flag_n = 1'b0, flag_z = 1'b0, flag_c = 1'b0, flag_v = 1'b0;
    logic        out_valid, br_taken, undef, swi;
    logic [31:0] br_target;

    int   checks = 0;
    int   errors = 0;
    int   cycles = 0;
    exp_t sb_q[$];

    always #4 clk = ~clk;

    sbt_branch_unit u_sbt_branch_unit (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .insn(insn), .pc(pc),
        .flag_n(flag_n), .flag_z(flag_z), .flag_c(flag_c), .flag_v(flag_v),
        .out_valid(out_valid), .br_taken(br_taken), .br_target(br_target),
        .undef(undef), .swi(swi)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic cond_ok(input logic [3:0] cc, input logic n, z, c, v);
        case (cc)
            4'h0: return z;            4'h1: return !z;
            4'h2: return c;            4'h3: return !c;
            4'h4: return n;            4'h5: return !n;
            4'h6: return v;            4'h7: return !v;
            4'h8: return c & !z;       4'h9: return !c | z;
            4'hA: return n == v;       4'hB: return n != v;
            4'hC: return !z & (n == v);
            4'hD: return z | (n != v);
            default: return 1'b0;
        endcase
    endfunction

    // req code: 2=R2 cond, 3=R3 uncond, 4=R4, 5=R5, 6=R6, 7=R7, 8=R8
    function automatic exp_t model(input logic [15:0] h, input logic [31:0] a,
                                   input logic n, z, c, v, input logic [7:0] req);
        exp_t e;
        int   off;
        e.taken = 0; e.undef = 0; e.swi = 0; e.target = a + 32'd2; e.req = req;
        if (h[15:12] == 4'b1101) begin
            if (h[11:8] == 4'hE) e.undef = 1;
            else if (h[11:8] == 4'hF) e.swi = 1;
            else if (cond_ok(h[11:8], n, z, c, v)) begin
                off = (h[7:0] >= 8'd128) ? int'(h[7:0]) - 256 : int'(h[7:0]);
                e.taken = 1;
                e.target = a + 32'(4 + 2 * off);
            end
        end else if (h[15:11] == 5'b11100) begin
            off = (h[10:0] >= 11'd1024) ? int'(h[10:0]) - 2048 : int'(h[10:0]);
            e.taken = 1;
            e.target = a + 32'(4 + 2 * off);
        end
        return e;
    endfunction

    task automatic drive(input logic [15:0] h, input logic [31:0] a,
                        input logic [3:0] nzcv, input logic [7:0] req);
        @(negedge clk);
        in_valid = 1'b1; insn = h; pc = a;
        {flag_n, flag_z, flag_c, flag_v} = nzcv;
        sb_q.push_back(model(h, a, nzcv[3], nzcv[2], nzcv[1], nzcv[0], req));
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
            insn = 16'hFFFF;
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (sb_q.size() == 0) begin
                check("R1 unexpected out_valid", 64'(out_valid), 64'd0);
            end else begin
                exp_t e;
                string tag;
                e = sb_q.pop_front();
                tag = $sformatf("R%0d", e.req);
                check({tag, " taken"}, 64'(br_taken), 64'(e.taken));
                check({tag, " target"}, 64'(br_target), 64'(e.target));
                check("R4 undef", 64'(undef), 64'(e.undef));
                check("R5 swi", 64'(swi), 64'(e.swi));
                check("R10 exclusive", 64'($countones({br_taken, undef, swi}) <= 1), 64'd1);
            end
        end
    end

    initial begin : watchdog
        while (cycles < 100000) begin
            @(posedge clk);
            cycles++;
        end
        errors++;
        checks++;
        $display("FAIL watchdog actual=%0d expected=<100000", cycles);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : stim
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9 reset state
        check("R9 out_valid", 64'(out_valid), 64'd0);
        check("R9 taken", 64'(br_taken), 64'd0);
        check("R9 target", 64'(br_target), 64'd0);
        check("R9 flags", 64'({undef, swi}), 64'd0);

        // R2 extremes, EQ with Z set
        drive(16'hD07F, 32'h0000_1000, 4'b0100, 8'd2);
        drive(16'hD080, 32'h0000_1000, 4'b0100, 8'd2);
        drive(16'hD000, 32'h0000_2000, 4'b0100, 8'd2);
        // R7 failed condition and non-branch halfwords
        drive(16'hD07F, 32'h0000_1000, 4'b0000, 8'd7);
        drive(16'h4140, 32'h0000_3000, 4'b1111, 8'd7);
        drive(16'hE800, 32'h0000_3002, 4'b0000, 8'd7);
        // R3 extremes, flags irrelevant
        drive(16'hE3FF, 32'h0001_0000, 4'b0000, 8'd3);
        drive(16'hE400, 32'h0001_0000, 4'b1111, 8'd3);
        // R4 / R5 reserved condition values
        drive(16'hDE12, 32'h0000_4000, 4'b1111, 8'd4);
        drive(16'hDF34, 32'h0000_4002, 4'b0000, 8'd5);
        idle(2);
        // R8 wrap forward and backward
        drive(16'hD17F, 32'hFFFF_FFFC, 4'b0000, 8'd8);
        drive(16'hE400, 32'h0000_0010, 4'b0000, 8'd8);
        drive(16'h4000, 32'hFFFF_FFFE, 4'b0000, 8'd8);
        // R6 every condition against every flag set
        for (int cc = 0; cc < 14; cc++) begin
            for (int f = 0; f < 16; f++) begin
                drive({4'hD, 4'(cc), 8'h10}, 32'h0000_8000 + 32'(cc * 64), 4'(f), 8'd6);
            end
        end
        idle(1);
        // R11 mixed stream with bubbles
        for (int i = 0; i < 400; i++) begin
            logic [15:0] h;
            h = 16'($urandom);
            if (i % 3 == 0) h[15:12] = 4'hD;
            if (i % 5 == 1) h[15:11] = 5'b11100;
            drive(h, {31'($urandom), 1'b0}, 4'($urandom), 8'd11);
            if (i % 7 == 0) idle(1);
        end
        idle(3);
        // R1 every queued result was delivered
        check("R1 drained", 64'(sb_q.size()), 64'd0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule